// File: doc/BRIEF.md
# Serial Programming-Mode Entry Receiver

This block sits on the reset/data line of a device and decides whether the device stays in normal operation or enters one of its programming or verify modes. The line must first be held high long enough to count as a real reset. A single low sample then marks the start of a fixed-length mode code. The code arrives one bit per clock, least significant bit first, on the same line. After the last bit, the line is held low to latch the code.

The latched code selects the target element: the user array, the key table, security bit 1 or security bit 2. The live levels of the supply-present input and the program-pulse input then choose between program and verify, or declare the combination illegal. Raising the line again at any time after the code has been received drops the mode and starts a new reset hold. The supply-present input is a plain digital level; no analog sensing is done here.

Top module: `pmode_entry_rx`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `mode_valid_o` is 0, `mode_tgt_o` is 0 and `mode_prog_o` is 0.
- R2: A code is only accepted if `data_rst_i` was sampled high on at least HOLD_CLKS consecutive rising edges (default 24, two 12-clock machine cycles) immediately before the start marker. A hold of 23 samples is ignored and the mode stays invalid.
- R3: The start marker is the first low sample that follows a qualifying hold. The next 10 samples are the code bits, and the first of them is bit 0 (least significant bit first).
- R4: Both `pulse_n_i` and `supply_hv_i` must be high on the start-marker sample. Otherwise the sequence is dropped and no mode is entered.
- R5: If the sample after the tenth bit is low, the code is latched. If it is high, the sequence is aborted, no mode is entered, and a new hold begins.
- R6: The codes are decoded as follows: 10'h2D3 selects the user array (`mode_tgt_o`=0), 10'h1A6 the key table (1), 10'h34B security bit 1 (2) and 10'h0E5 security bit 2 (3).
- R7: While a known code is latched, the mode depends on the supply and pulse inputs sampled at each edge. With `supply_hv_i`=1 the mode is program (`mode_prog_o`=1). With `supply_hv_i`=0 and `pulse_n_i`=1 the mode is verify (`mode_prog_o`=0). With both low, `mode_valid_o` is 0.
- R8: A latched code that matches none of the four values in R6 leaves `mode_valid_o` at 0.
- R9: A high sample of `data_rst_i` while a mode is latched clears `mode_valid_o` at that same edge. A new hold begins, and the high sample counts as its first.
- R10: Outputs are registered and change at the rising edge that samples the causing input. Whenever `mode_valid_o` is 0, `mode_tgt_o` and `mode_prog_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| data_rst_i | input | 1 | Combined reset / serial code line |
| pulse_n_i | input | 1 | Level of the active-low program-pulse pin |
| supply_hv_i | input | 1 | High when the programming supply is present |
| mode_tgt_o | output | 2 | Selected target: 0 user array, 1 key table, 2 security bit 1, 3 security bit 2 |
| mode_prog_o | output | 1 | 1 for program, 0 for verify |
| mode_valid_o | output | 1 | A defined mode is active |

## Verification
The assertions are checked on every cycle. They cover the following relations that can be seen at the ports:
- the target and operation fields read zero whenever no mode is valid;
- a valid mode is always preceded by a low sample of the line;
- a high sample ends any valid mode on the next edge;
- the legal pin combination and the program/verify bit follow the supply and pulse levels of the previous edge.

The minimum reset hold, the LSB-first bit order, the start-marker pin check, the abort on a high stop sample and the rejection of unknown codes depend on whole input sequences. Only the bench's scenarios show these. The bench checks them against a behavioural reference model compared on every clock.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_HOLD   = 3'd1,
    ST_SHIFT  = 3'd2,
    ST_STOP   = 3'd3,
    ST_LATCH  = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    TGT_USER = 2'd0,
    TGT_KEY  = 2'd1,
    TGT_SEC1 = 2'd2,
    TGT_SEC2 = 2'd3
  } target_e;

  localparam int unsigned NUM_TGT = 4;

  typedef struct packed {
    logic    hit;
    target_e tgt;
  } decode_t;

endpackage

// File: rtl/pmode_rst_sync.sv
module pmode_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pmode_hold_timer.sv
module pmode_hold_timer #(
  parameter int unsigned HOLD_CLKS = 24,
  localparam int unsigned CNT_W    = $clog2(HOLD_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,   // load count of one (first high sample)
  input  logic inc_i,     // another high sample seen
  output logic hold_ok_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CLKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i | inc_i;
    cnt_d  = cnt_q;
    if (start_i) begin
      cnt_d = CNT_W'(1);
    end else if (inc_i && (cnt_q < LIMIT)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hold_ok_o = (cnt_q >= LIMIT);

endmodule

// File: rtl/pmode_shifter.sv
module pmode_shifter #(
  parameter int unsigned CODE_W = 10,
  localparam int unsigned BIT_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o   // current shift is the final bit
);

  logic [CODE_W-1:0] sr_q, sr_d;
  logic [BIT_W-1:0]  cnt_q, cnt_d;
  logic              upd_en;

  always_comb begin
    upd_en = clr_i | en_i;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (en_i) begin
      // least significant bit arrives first and ends up at position 0
      sr_d  = {bit_i, sr_q[CODE_W-1:1]};
      cnt_d = cnt_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign code_o = sr_q;
  assign last_o = en_i && (cnt_q == BIT_W'(CODE_W - 1));

endmodule

// File: rtl/pmode_decoder.sv
module pmode_decoder
  import pmode_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter logic [NUM_TGT-1:0][CODE_W-1:0] CODES = '0
) (
  input  logic [CODE_W-1:0] code_i,
  output decode_t           dec_o
);

  logic [NUM_TGT-1:0] hit;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_cmp
    assign hit[g] = (code_i == CODES[g]);
  end

  always_comb begin
    dec_o.hit = |hit;
    dec_o.tgt = TGT_USER;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (hit[i]) dec_o.tgt = target_e'(i);
    end
  end

endmodule

// File: rtl/pmode_entry_rx.sv
module pmode_entry_rx
  import pmode_pkg::*;
#(
  parameter int unsigned CODE_W       = 10,
  parameter int unsigned CLKS_PER_MC  = 12,
  parameter int unsigned HOLD_MC      = 2,
  parameter logic [CODE_W-1:0] CODE_USER = 10'h2D3,
  parameter logic [CODE_W-1:0] CODE_KEY  = 10'h1A6,
  parameter logic [CODE_W-1:0] CODE_SEC1 = 10'h34B,
  parameter logic [CODE_W-1:0] CODE_SEC2 = 10'h0E5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_rst_i,
  input  logic       pulse_n_i,
  input  logic       supply_hv_i,
  output logic [1:0] mode_tgt_o,
  output logic       mode_prog_o,
  output logic       mode_valid_o
);

  localparam int unsigned HOLD_CLKS = CLKS_PER_MC * HOLD_MC;
  localparam logic [NUM_TGT-1:0][CODE_W-1:0] CODES =
    {CODE_SEC2, CODE_SEC1, CODE_KEY, CODE_USER};

  logic              rst_s_n;
  rx_state_e         st_q, st_d;
  logic              hold_start, hold_inc, hold_ok;
  logic              sh_clr, sh_en, sh_last;
  logic [CODE_W-1:0] code;
  decode_t           dec;
  logic              pins_legal;
  logic              valid_d, prog_d;
  logic [1:0]        tgt_d;
  logic              valid_q, prog_q;
  logic [1:0]        tgt_q;

  pmode_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  pmode_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start_i   (hold_start),
    .inc_i     (hold_inc),
    .hold_ok_o (hold_ok)
  );

  pmode_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr_i  (sh_clr),
    .en_i   (sh_en),
    .bit_i  (data_rst_i),
    .code_o (code),
    .last_o (sh_last)
  );

  pmode_decoder #(.CODE_W(CODE_W), .CODES(CODES)) u_dec (
    .code_i (code),
    .dec_o  (dec)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL: if (data_rst_i) st_d = ST_HOLD;
      ST_HOLD: begin
        if (data_rst_i) begin
          st_d = ST_HOLD;
        end else if (hold_ok && pulse_n_i && supply_hv_i) begin
          st_d = ST_SHIFT;   // this low sample is the start marker
        end else begin
          st_d = ST_NORMAL;
        end
      end
      ST_SHIFT: if (sh_last) st_d = ST_STOP;
      ST_STOP:  st_d = data_rst_i ? ST_HOLD : ST_LATCH;
      ST_LATCH: if (data_rst_i) st_d = ST_HOLD;
      default:  st_d = ST_NORMAL;
    endcase
  end

  // datapath enables
  always_comb begin
    hold_start = (st_q != ST_HOLD) && (st_d == ST_HOLD);
    hold_inc   = (st_q == ST_HOLD) && data_rst_i;
    sh_en      = (st_q == ST_SHIFT);
    sh_clr     = ((st_q == ST_HOLD) && (st_d == ST_SHIFT)) || hold_start;
  end

  // output decode
  always_comb begin
    pins_legal = supply_hv_i || pulse_n_i;
    valid_d    = (st_d == ST_LATCH) && dec.hit && pins_legal;
    tgt_d      = valid_d ? dec.tgt : 2'd0;
    prog_d     = valid_d && supply_hv_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_NORMAL;
      valid_q <= 1'b0;
      tgt_q   <= 2'd0;
      prog_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      tgt_q   <= tgt_d;
      prog_q  <= prog_d;
    end
  end

  assign mode_valid_o = valid_q;
  assign mode_tgt_o   = tgt_q;
  assign mode_prog_o  = prog_q;

endmodule

// File: rtl/pmode_entry_chk.sv
module pmode_entry_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_rst_i,
  input logic       pulse_n_i,
  input logic       supply_hv_i,
  input logic [1:0] mode_tgt_o,
  input logic       mode_prog_o,
  input logic       mode_valid_o
);

  // R10
  idle_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_valid_o |-> (mode_tgt_o == 2'd0) && !mode_prog_o);

  // R5
  valid_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_o |-> $past(!data_rst_i));

  // R9
  high_drops_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid_o && data_rst_i) |=> !mode_valid_o);

  // R7
  legal_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_o |-> $past(supply_hv_i || pulse_n_i));

  // R7
  prog_follows_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_o |-> (mode_prog_o == $past(supply_hv_i)));

endmodule

bind pmode_entry_rx pmode_entry_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .data_rst_i   (data_rst_i),
  .pulse_n_i    (pulse_n_i),
  .supply_hv_i  (supply_hv_i),
  .mode_tgt_o   (mode_tgt_o),
  .mode_prog_o  (mode_prog_o),
  .mode_valid_o (mode_valid_o)
);

// File: tb/tb_pmode_entry_rx.sv
`timescale 1ns/1ps
module tb_pmode_entry_rx;

  localparam int HOLD = 24;
  localparam logic [9:0] C_USER = 10'h2D3, C_KEY = 10'h1A6,
                         C_SEC1 = 10'h34B, C_SEC2 = 10'h0E5;

  logic clk = 1'b0;
  logic rst_n;
  logic rp, pgm_n, vpp;
  logic [1:0] tgt;
  logic prog, valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pmode_entry_rx dut (
    .clk(clk), .rst_n(rst_n), .data_rst_i(rp), .pulse_n_i(pgm_n),
    .supply_hv_i(vpp), .mode_tgt_o(tgt), .mode_prog_o(prog), .mode_valid_o(valid)
  );

  // behavioural reference model
  int   ph;        // 0 normal, 1 holding, 2 receiving, 3 waiting stop, 4 latched
  int   hold_cnt;
  bit   bits[$];
  int   code_v;
  bit   m_valid, m_prog;
  int   m_tgt;

  function automatic int lookup(int c);
    if (c == C_USER) return 0;
    if (c == C_KEY)  return 1;
    if (c == C_SEC1) return 2;
    if (c == C_SEC2) return 3;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; hold_cnt = 0; bits.delete(); code_v = 0;
      m_valid = 0; m_prog = 0; m_tgt = 0;
    end else begin
      if (ph == 0) begin
        if (rp) begin ph = 1; hold_cnt = 1; end
      end else if (ph == 1) begin
        if (rp) hold_cnt++;
        else if (hold_cnt >= HOLD && pgm_n && vpp) begin ph = 2; bits.delete(); end
        else ph = 0;
      end else if (ph == 2) begin
        bits.push_back(rp);
        if (bits.size() == 10) ph = 3;
      end else if (ph == 3) begin
        if (rp) begin ph = 1; hold_cnt = 1; end
        else begin
          ph = 4; code_v = 0;
          foreach (bits[i]) code_v |= int'(bits[i]) << i;
        end
      end else begin
        if (rp) begin ph = 1; hold_cnt = 1; end
      end
      m_valid = (ph == 4) && (lookup(code_v) >= 0) && (vpp || pgm_n);
      m_tgt   = m_valid ? lookup(code_v) : 0;
      m_prog  = m_valid && vpp;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(valid == m_valid, "R10 valid vs model", valid, m_valid);
      check(tgt == 2'(m_tgt), "R10 target vs model", tgt, m_tgt);
      check(prog == m_prog, "R10 prog vs model", prog, m_prog);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rp = 0;
    end
  endtask

  // hold, start marker, ten bits LSB first, stop sample
  task automatic send(input logic [9:0] c, input int hold, input bit pin_ok,
                      input bit stop_lvl);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); rp = 1; pgm_n = 1; vpp = 1;
    end
    @(negedge clk); rp = 0; pgm_n = pin_ok; vpp = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rp = c[i]; pgm_n = 1;
    end
    @(negedge clk); rp = stop_lvl;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; rp = 0; pgm_n = 1; vpp = 1;
    repeat (3) @(negedge clk);
    // R1
    check(valid == 0 && tgt == 0 && prog == 0, "R1 reset state", valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(valid == 0, "R1 after release", valid, 0);

    // R6 user array, program
    send(C_USER, HOLD + 3, 1, 0);
    check(valid == 1 && tgt == 0, "R6 user target", tgt, 0);
    check(prog == 1, "R7 program with supply", prog, 1);
    send(C_KEY, HOLD, 1, 0);
    check(valid == 1 && tgt == 1, "R6 key target", tgt, 1);
    send(C_SEC1, HOLD, 1, 0);
    check(valid == 1 && tgt == 2, "R6 sec1 target", tgt, 2);
    send(C_SEC2, HOLD, 1, 0);
    check(valid == 1 && tgt == 3, "R6 sec2 target", tgt, 3);

    // R7 verify and illegal combination
    vpp = 0; pgm_n = 1; @(negedge clk);
    check(valid == 1 && prog == 0, "R7 verify mode", prog, 0);
    pgm_n = 0; @(negedge clk);
    check(valid == 0, "R7 illegal pins", valid, 0);
    pgm_n = 1; vpp = 1; @(negedge clk);
    check(valid == 1 && prog == 1, "R7 program again", valid, 1);

    // R9 line high while latched
    rp = 1; @(negedge clk);
    check(valid == 0, "R9 high clears mode", valid, 0);
    idle(2);
    check(valid == 0, "R9 stays normal", valid, 0);

    // R3 reversed bit order rejected
    send({<<{C_USER}}, HOLD, 1, 0);
    check(valid == 0, "R3 reversed order", valid, 0);

    // R2 hold boundary
    send(C_KEY, HOLD - 1, 1, 0);
    check(valid == 0, "R2 short hold", valid, 0);
    send(C_KEY, HOLD, 1, 0);
    check(valid == 1 && tgt == 1, "R2 exact hold", valid, 1);

    // R4 pulse pin low at start marker
    send(C_USER, HOLD, 0, 0);
    check(valid == 0, "R4 pin low at start", valid, 0);

    // R5 stop sample high aborts
    send(C_USER, HOLD, 1, 1);
    check(valid == 0, "R5 high stop aborts", valid, 0);
    idle(2);
    check(valid == 0, "R5 no mode after abort", valid, 0);

    // R8 unknown code
    send(10'h000, HOLD, 1, 0);
    check(valid == 0, "R8 unknown code zero", valid, 0);
    send(10'h3FF, HOLD, 1, 0);
    check(valid == 0, "R8 unknown code ones", valid, 0);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule